// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

A single 16-bit pulse-width timer channel. An 8-bit prescaler and a selectable power-of-two divider (2, 4, 8 or 16) produce a timer tick. On each tick a down counter steps toward zero. The output level comes from comparing the counter with an active compare register. Count and compare values are written into shadow buffers. The buffers reach the live registers only when the timer starts, at a zero reload in auto-reload mode, or through an explicit load while the timer is idle. Period and duty therefore change without glitches.

When the counter is at zero on a tick, the channel emits a one-clock interrupt pulse. It then either reloads from the buffers (auto-reload) or stops (one-shot). A non-overlap generator drives a true output and a complementary output. It holds back every rising edge of either output by a programmable number of prescaler ticks, so a half-bridge pair is never on at the same time.

Software uses a simple write port with a 2-bit address:
- 0: count buffer.
- 1: compare buffer.
- 2: clock settings. Bits [7:0] hold the prescaler value P. Bits [9:8] hold the divider select S.
- 3: control. Bit 0 is run. Bit 1 is manual load. Bit 2 is auto-reload. Bit 3 is invert. Bit 4 is dead-zone enable. Bits [15:8] hold the dead-zone length L.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, all registers are zero. pwm_o is 1, pwm_n_o is 0 and irq_o is 0.
- R2: The prescaler pulses once every P+1 clocks. A timer tick occurs every (P+1)*2^(S+1) clocks, where S=0..3 selects divide by 2, 4, 8 or 16.
- R3: Writing control with run=1 while the timer is stopped copies both buffers into the counter and the compare register on that write's clock edge.
- R4: While running, each tick decrements a nonzero counter by one. The raw level is 0 while counter > compare and 1 while counter <= compare. Invert=1 flips the raw level.
- R5: A tick with the counter at zero and run set raises irq_o for exactly one clock on the next cycle. With auto-reload set, both buffers are reloaded on that same tick.
- R6: In one-shot mode (auto-reload=0), a zero tick leaves the counter at zero and clears run. No further interrupt follows until the timer is started again.
- R7: After run is cleared, the counter and compare register hold their values. No reload and no interrupt occur.
- R8: Buffer writes made while the timer is running do not affect the counter or compare register until the next zero reload.
- R9: A control write with run=0 and manual load=1, made while the timer is stopped, loads both buffers at once. The manual load bit has no effect while the timer is running.
- R10: With the dead-zone enabled and L>0, each rising edge of pwm_o and of pwm_n_o comes L prescaler pulses after the raw level changes. The two outputs are never high together. With the dead-zone disabled, pwm_n_o is the exact complement of pwm_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 count buffer, 1 compare buffer, 2 clock, 3 control |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM output, with dead time when enabled |
| pwm_n_o | output | 1 | Complementary output, with dead time when enabled |
| irq_o | output | 1 | One-clock interrupt pulse at zero |

## Verification
The assertions rely on three conditions:
- Write data is always defined when a write is strobed.
- A manual load is only requested while the timer is stopped.
- The divider always spaces ticks by at least two clocks, which is what keeps the interrupt to a single clock.

The stimulus meets these conditions. Every write is applied between clock edges, one write per cycle. Settings change only in ways the reference model can follow cycle by cycle. Each case runs long enough to reach several zero crossings before the next setting is applied.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PRE_W = 8;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned DZ_W  = 8;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CMP   = 2'd1,
    REG_CLK   = 2'd2,
    REG_CTRL  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [DZ_W-1:0] dz_len;
    logic [2:0]      rsvd;
    logic            dz_en;
    logic            invert;
    logic            auto_rl;
    logic            manual;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/pwm_clk_div.sv
module pwm_clk_div #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pre_tick_o,
  output logic             tick_o
);
  localparam int unsigned DIV_W = 2 ** SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign pre_tick_o = (pre_q >= presc_i);
  // wraps to all ones for the largest select
  assign mask   = (DIV_W'(2) << sel_i) - DIV_W'(1);
  assign tick_o = pre_tick_o && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_tick_o) begin
      pre_q <= '0;
      div_q <= div_q + DIV_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  a_r2_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             auto_rl_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             done_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             zero_hit;

  assign zero_hit = run_i && tick_i && (cnt_q == '0);
  assign done_o   = zero_hit && !auto_rl_i;
  assign cnt_o    = cnt_q;
  assign cmp_o    = cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= zero_hit;
      if (load_i) begin
        cnt_q <= cnt_buf_i;
        cmp_q <= cmp_buf_i;
      end else if (run_i && tick_i) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (auto_rl_i) begin
          cnt_q <= cnt_buf_i;
          cmp_q <= cmp_buf_i;
        end
      end
    end
  end

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> ($stable(cnt_q) && $stable(cmp_q)));
  a_r8_cmp_at_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(zero_hit && auto_rl_i)) |=> $stable(cmp_q));
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(cnt_buf_i) && cmp_q == $past(cmp_buf_i)));
  a_r5_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/pwm_dead_zone.sv
module pwm_dead_zone #(
  parameter int unsigned DZ_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwm_i,
  input  logic            pre_tick_i,
  input  logic            dz_en_i,
  input  logic [DZ_W-1:0] dz_len_i,
  output logic            pwm_o,
  output logic            pwm_n_o
);
  logic            prev_q;
  logic [DZ_W-1:0] age_q;
  logic            settled;

  assign settled = (dz_len_i == '0) || ((pwm_i == prev_q) && (age_q >= dz_len_i));

  always_comb begin
    if (dz_en_i) begin
      pwm_o   = pwm_i && settled;
      pwm_n_o = !pwm_i && settled;
    end else begin
      pwm_o   = pwm_i;
      pwm_n_o = !pwm_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      age_q  <= '0;
    end else begin
      prev_q <= pwm_i;
      if (pwm_i != prev_q)                  age_q <= '0;
      else if (pre_tick_i && (&age_q) == 1'b0) age_q <= age_q + DZ_W'(1);
    end
  end

  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_o && pwm_n_o));
  a_r10_edge_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dz_en_i && dz_len_i != '0 && pwm_i != prev_q) |-> (!pwm_o && !pwm_n_o));
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             pwm_n_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_buf_q, cmp_buf_q, cnt, cmp;
  logic [PRE_W-1:0] presc_q;
  logic [SEL_W-1:0] sel_q;
  logic             run_q, auto_rl_q, inv_q, dz_en_q;
  logic [DZ_W-1:0]  dz_len_q;
  logic             wr_ctrl, load, done, pre_tick, tick, raw;
  ctrl_t            wctrl;

  assign wctrl   = ctrl_t'(wr_data_i);
  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);
  // start, or manual load while staying stopped
  assign load    = wr_ctrl && !run_q && (wctrl.run || wctrl.manual);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_buf_q <= '0;
      cmp_buf_q <= '0;
      presc_q   <= '0;
      sel_q     <= '0;
      run_q     <= 1'b0;
      auto_rl_q <= 1'b0;
      inv_q     <= 1'b0;
      dz_en_q   <= 1'b0;
      dz_len_q  <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == REG_COUNT) cnt_buf_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == REG_CMP)   cmp_buf_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == REG_CLK) begin
        presc_q <= wr_data_i[PRE_W-1:0];
        sel_q   <= wr_data_i[PRE_W +: SEL_W];
      end
      if (wr_ctrl) begin
        run_q     <= wctrl.run;
        auto_rl_q <= wctrl.auto_rl;
        inv_q     <= wctrl.invert;
        dz_en_q   <= wctrl.dz_en;
        dz_len_q  <= wctrl.dz_len;
      end else if (done) begin
        run_q <= 1'b0;
      end
    end
  end

  pwm_clk_div #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_clk_div (
    .clk_i, .rst_ni, .presc_i(presc_q), .sel_i(sel_q),
    .pre_tick_o(pre_tick), .tick_o(tick)
  );

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .run_i(run_q), .tick_i(tick), .load_i(load),
    .auto_rl_i(auto_rl_q), .cnt_buf_i(cnt_buf_q), .cmp_buf_i(cmp_buf_q),
    .cnt_o(cnt), .cmp_o(cmp), .done_o(done), .irq_o(irq_o)
  );

  assign raw = (cnt <= cmp) ^ inv_q;

  pwm_dead_zone #(.DZ_W(DZ_W)) u_dz (
    .clk_i, .rst_ni, .pwm_i(raw), .pre_tick_i(pre_tick),
    .dz_en_i(dz_en_q), .dz_len_i(dz_len_q), .pwm_o(pwm_o), .pwm_n_o(pwm_n_o)
  );

  a_r6_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !wr_ctrl) |=> !run_q);
  a_r9_no_load_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> !load);
endmodule

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm, pwm_n, irq;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  always #10 clk = ~clk;

  pwm_timer_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .pwm_n_o(pwm_n), .irq_o(irq)
  );

  // behavioural reference
  int m_cnt, m_cmp, m_cbuf, m_pbuf, m_presc, m_sel, m_pre, m_div;
  int m_run, m_ar, m_inv, m_dzen, m_dzlen, m_prev, m_age, m_irq;
  int dv, pt, tk, ld, zh, raw_now;

  function automatic int raw_lvl();
    return ((m_cnt <= m_cmp) ? 1 : 0) ^ m_inv;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_cbuf = 0; m_pbuf = 0; m_presc = 0; m_sel = 0;
      m_pre = 0; m_div = 0; m_run = 0; m_ar = 0; m_inv = 0; m_dzen = 0;
      m_dzlen = 0; m_prev = 0; m_age = 0; m_irq = 0;
    end else begin
      dv = 2 << m_sel;
      pt = (m_pre >= m_presc);
      tk = pt && ((m_div % dv) == dv - 1);
      ld = wr_en && wr_addr == 3 && !m_run && (wr_data[0] || wr_data[1]);
      zh = m_run && tk && m_cnt == 0;
      raw_now = raw_lvl();
      m_irq = zh;
      if (m_age > 255) m_age = 255;
      if (raw_now != m_prev) m_age = 0; else if (pt && m_age < 255) m_age++;
      m_prev = raw_now;
      if (ld) begin m_cnt = m_cbuf; m_cmp = m_pbuf; end
      else if (m_run && tk) begin
        if (m_cnt != 0) m_cnt--;
        else if (m_ar) begin m_cnt = m_cbuf; m_cmp = m_pbuf; end
      end
      if (pt) begin m_pre = 0; m_div = (m_div + 1) % 16; end else m_pre++;
      if (wr_en && wr_addr == 3) begin
        m_run = wr_data[0]; m_ar = wr_data[2]; m_inv = wr_data[3];
        m_dzen = wr_data[4]; m_dzlen = wr_data[15:8];
      end else if (zh && !m_ar) m_run = 0;
      if (wr_en && wr_addr == 0) m_cbuf = wr_data;
      if (wr_en && wr_addr == 1) m_pbuf = wr_data;
      if (wr_en && wr_addr == 2) begin m_presc = wr_data[7:0]; m_sel = wr_data[9:8]; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      int r, st, ep, en;
      r  = raw_lvl();
      st = (m_dzlen == 0) || (r == m_prev && m_age >= m_dzlen);
      ep = m_dzen ? (r && st) : r;
      en = m_dzen ? (!r && st) : !r;
      chk({pwm, pwm_n, irq} == {ep[0], en[0], m_irq[0]}, cur_req,
          {pwm, pwm_n, irq}, {ep[0], en[0], m_irq[0]});
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected 0 at cycle %0d", cyc, cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(output int t);
    t = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) begin t = cyc; break; end
    end
  endtask

  initial begin
    int t1, t2, n_irq;
    logic sp, sn;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pwm == 1'b1 && pwm_n == 1'b0 && irq == 1'b0, "R1", {pwm, pwm_n, irq}, 3'b100);
    rst_n = 1'b1;
    idle(2);
    chk(pwm == 1'b1 && pwm_n == 1'b0, "R1", {pwm, pwm_n}, 2'b10);

    // R3 R4 R5: start with auto-reload, fastest tick
    cur_req = "R3";
    wr(0, 16'd5); wr(1, 16'd2); wr(2, 16'h0000);
    wr(3, 16'h0005);
    cur_req = "R4";
    idle(60);
    cur_req = "R5";
    idle(40);

    // R2: P=2, S=2 -> tick every 24 clocks, period 6 ticks = 144 clocks
    cur_req = "R2";
    wr(2, 16'h0202);
    wait_irq(t1); wait_irq(t1); wait_irq(t2);
    chk(t2 - t1 == 144, "R2", t2 - t1, 144);

    // R8: buffer writes while running
    cur_req = "R8";
    wr(2, 16'h0100);
    wr(0, 16'd3); wr(1, 16'd1);
    idle(120);

    // R4 invert, R10 dead-zone with L=3
    cur_req = "R10";
    wr(3, 16'h0315);
    idle(80);
    wr(3, 16'h031D);
    idle(80);
    wr(0, 16'd9); wr(1, 16'd4);
    wr(3, 16'h0115);
    idle(120);

    // R7: clear run, outputs and interrupt stay put
    cur_req = "R7";
    wr(3, 16'h0004);
    idle(2);
    sp = pwm; sn = pwm_n; n_irq = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); n_irq += irq; end
    chk(pwm == sp && pwm_n == sn && n_irq == 0, "R7", {pwm, pwm_n, n_irq[0]}, {sp, sn, 1'b0});

    // R9: manual load while stopped; ignored while running
    cur_req = "R9";
    wr(0, 16'd7); wr(1, 16'd7);
    wr(3, 16'h0002);
    idle(3);
    chk(pwm == 1'b1, "R9", pwm, 1);
    wr(0, 16'd6); wr(1, 16'd0);
    wr(3, 16'h0005);
    wr(0, 16'd12); wr(1, 16'd3);
    wr(3, 16'h0007);
    idle(80);

    // R6: one-shot
    cur_req = "R6";
    wr(3, 16'h0000);
    wr(0, 16'd4); wr(1, 16'd1);
    wr(3, 16'h0001);
    n_irq = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); n_irq += irq; end
    chk(n_irq == 1, "R6", n_irq, 1);
    chk(pwm == 1'b1, "R6", pwm, 1);
    // restart, divide by 16, slowest select
    wr(2, 16'h0300);
    wr(3, 16'h0001);
    idle(200);

    finish_run();
  end
endmodule